// File: doc/BRIEF.md
# DPCD AUX Burst Transfer Sequencer

This block performs a native AUX read or write of any length at a 20-bit DPCD address. The caller gives a start pulse with a direction, a base address and a byte count. The sequencer then splits the transfer into bursts of at most sixteen bytes. For each burst it runs a request/reply handshake with a lower-level AUX engine. A burst that fails is retried, and the sequencer steps through the target address until the whole count has been moved. It then signals completion with a one-cycle pulse and an error code.

Bytes move between the sequencer and the caller one at a time through an indexed buffer port.

- **Write:** the sequencer fetches the payload from the caller at `usr_idx`, one byte per cycle, and fills its burst buffer before each engine request.
- **Read:** the reply bytes are held in the burst buffer. They are handed to the caller only after the burst has passed every check.

The engine side has the following signals:

- a held enable (`eng_go`) that the engine clears with `eng_accept`;
- an 8-bit command;
- the address split into three fields;
- a reply pulse that carries an error flag, a 4-bit status and the read data.

Timeouts are counted in clock cycles. A parameter sets the number of cycles in one millisecond.

Top module: `dpcd_burst_seq`

## Requirements
- R1: A start with a byte count of zero raises `done` in the next cycle with `err_code` 0, and no engine request is made.
- R2: Each burst carries `min(remaining, 16)` bytes, so the last burst carries the remainder. Command bits 7:4 hold the burst length minus one.
- R3: Command bit 3 is 1 (native transaction), bits 2:1 are 0, and bit 0 is 1 for a read and 0 for a write.
- R4: The engine address is split into three fields: `eng_addr_lo` carries address bits 7:0, `eng_addr_mid` carries bits 15:8 and `eng_addr_hi` carries bits 19:16. After a successful burst the address advances by the burst length, with carry across the 20 bits. The address is stable while `eng_go` is held.
- R5: Each burst gets at most 10 attempts. After the tenth failure the transfer ends with `done` and the code of the last failure.
- R6: An attempt passes four checks in this order, and the first check that fails gives the error code:
  - `eng_accept` must arrive within 20 ms of cycles while `eng_go` is held (code 1);
  - the reply must arrive within 10 ms after the accept (code 2);
  - the reply error flag must be clear (code 3);
  - the reply status must be zero (code 4).
  An error flag together with a non-zero status therefore reports code 3.
- R7: The burst buffer is cleared before every attempt. Write-data bytes beyond the burst length are zero, and on a read every write-data byte is zero.
- R8: For a write, byte i of a burst at transfer offset k is taken from the caller at index k+i and is loaded before `eng_go` rises.
- R9: Read data reaches the caller only after a burst succeeds. It arrives one byte per cycle on `usr_we`, in ascending index order, with exactly the burst length in bytes and never on a write transfer.
- R10: A start pulse while `busy` is high is ignored.
- R11: `done` lasts exactly one cycle, and `busy` is low in the cycle after it. Success is reported with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start pulse, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Base DPCD address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | 0 ok, 1 enable timeout, 2 reply timeout, 3 error flag, 4 bad status |
| usr_idx | output | LEN_W | Caller buffer index for the current byte |
| usr_wdata | input | 8 | Caller byte at `usr_idx` (write payload) |
| usr_we | output | 1 | Read byte strobe toward the caller |
| usr_rdata | output | 8 | Read byte toward the caller |
| eng_go | output | 1 | Engine enable, held until accepted or timed out |
| eng_cmd | output | 8 | Command: length-1, native bit, direction |
| eng_addr_lo | output | 8 | Address bits 7:0 |
| eng_addr_mid | output | 8 | Address bits 15:8 |
| eng_addr_hi | output | 4 | Address bits 19:16 |
| eng_wdata | output | BURST*8 | Burst buffer contents, byte i at bits 8i+7:8i |
| eng_accept | input | 1 | Engine clears the enable |
| eng_reply | input | 1 | Reply received pulse |
| eng_err | input | 1 | Access error flag, valid with the reply |
| eng_status | input | 4 | Reply status, valid with the reply |
| eng_rdata | input | BURST*8 | Reply data, valid with the reply |

## Verification
The bench builds the block with `CYC_PER_MS` set to 4. This shortens the enable timeout to 80 cycles and the reply timeout to 40 cycles. As a result, ten consecutive timeouts can be run to the abort in a few hundred cycles. `BURST` and `MAX_TRY` keep their defaults of 16 and 10. Transfer lengths of 5, 16, 20 and 40 bytes give single, exact and multi-burst splits, and a base address just below a 64 KiB boundary makes the address carry into the upper field.

// File: rtl/dpcd_seq_pkg.sv
package dpcd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LOAD,
        ST_ISSUE,
        ST_WAIT,
        ST_CHECK,
        ST_UNLOAD,
        ST_ADVANCE
    } seq_state_e;

    localparam logic [2:0] ERR_NONE     = 3'd0;
    localparam logic [2:0] ERR_EN_TMO   = 3'd1;
    localparam logic [2:0] ERR_RPLY_TMO = 3'd2;
    localparam logic [2:0] ERR_ACCESS   = 3'd3;
    localparam logic [2:0] ERR_STATUS   = 3'd4;

    localparam int CMD_READ_BIT   = 0;
    localparam int CMD_NATIVE_BIT = 3;
    localparam int CMD_LEN_LSB    = 4;

endpackage

// File: rtl/dpcd_burst_buf.sv
module dpcd_burst_buf #(
    parameter int BYTES = 16,
    parameter int IDX_W = $clog2(BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_byte,
    input  logic                 cap_en,
    input  logic [BYTES*8-1:0]   cap_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           rd_byte,
    output logic [BYTES*8-1:0]   data
);

    logic [7:0] mem_q [BYTES];
    logic [7:0] mem_d [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        always_comb begin
            mem_d[g] = mem_q[g];
            if (clr)
                mem_d[g] = 8'h00;
            else if (cap_en)
                mem_d[g] = cap_data[g*8 +: 8];
            else if (wr_en && (wr_idx == IDX_W'(g)))
                mem_d[g] = wr_byte;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= 8'h00;
            else        mem_q[g] <= mem_d[g];
        end

        assign data[g*8 +: 8] = mem_q[g];
    end

    assign rd_byte = mem_q[rd_idx];

    // a clear leaves every byte zero on the following cycle
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (data == '0));

endmodule

// File: rtl/dpcd_cycle_timer.sv
module dpcd_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         hit
);

    logic [W-1:0] cnt_d, cnt_q;

    assign hit = (cnt_q == lim - W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (!hit) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // a running window never counts past its limit
    assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt_q < lim));

endmodule

// File: rtl/dpcd_burst_seq.sv
module dpcd_burst_seq
    import dpcd_seq_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int BURST       = 16,
    parameter int MAX_TRY     = 10,
    parameter int CYC_PER_MS  = 100000,
    parameter int EN_TMO_MS   = 20,
    parameter int RPLY_TMO_MS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_start,
    input  logic               req_write,
    input  logic [19:0]        req_addr,
    input  logic [LEN_W-1:0]   req_len,
    output logic               busy,
    output logic               done,
    output logic [2:0]         err_code,
    output logic [LEN_W-1:0]   usr_idx,
    input  logic [7:0]         usr_wdata,
    output logic               usr_we,
    output logic [7:0]         usr_rdata,
    output logic               eng_go,
    output logic [7:0]         eng_cmd,
    output logic [7:0]         eng_addr_lo,
    output logic [7:0]         eng_addr_mid,
    output logic [3:0]         eng_addr_hi,
    output logic [BURST*8-1:0] eng_wdata,
    input  logic               eng_accept,
    input  logic               eng_reply,
    input  logic               eng_err,
    input  logic [3:0]         eng_status,
    input  logic [BURST*8-1:0] eng_rdata
);

    localparam int IDX_W   = $clog2(BURST);
    localparam int BLEN_W  = $clog2(BURST + 1);
    localparam int TRY_W   = $clog2(MAX_TRY);
    localparam int EN_LIM  = EN_TMO_MS * CYC_PER_MS;
    localparam int RP_LIM  = RPLY_TMO_MS * CYC_PER_MS;
    localparam int MAX_LIM = (EN_LIM > RP_LIM) ? EN_LIM : RP_LIM;
    localparam int TMR_W   = $clog2(MAX_LIM + 1);

    typedef struct packed {
        seq_state_e         st;
        logic               wr;
        logic [19:0]        addr;
        logic [LEN_W-1:0]   ptr;
        logic [LEN_W-1:0]   rem;
        logic [BLEN_W-1:0]  blen;
        logic [IDX_W-1:0]   idx;
        logic [TRY_W-1:0]   tries;
        logic               rflag;
        logic               eflag;
        logic [3:0]         status;
        logic               done;
        logic [2:0]         err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             buf_clr, buf_wr, buf_cap;
    logic             tmr_clr, tmr_hit;
    logic [TMR_W-1:0] tmr_lim;
    logic             fail;
    logic [2:0]       fail_code;
    logic [BLEN_W-1:0] blen_m1;
    logic             idx_last;

    function automatic logic [BLEN_W-1:0] burst_of(input logic [LEN_W-1:0] left);
        if (left > LEN_W'(BURST)) return BLEN_W'(BURST);
        return left[BLEN_W-1:0];
    endfunction

    assign blen_m1  = r_q.blen - BLEN_W'(1);
    assign idx_last = (BLEN_W'(r_q.idx) == blen_m1);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        buf_cap   = 1'b0;
        tmr_clr   = 1'b1;
        tmr_lim   = TMR_W'(RP_LIM);
        fail      = 1'b0;
        fail_code = ERR_NONE;
        case (r_q.st)
            ST_IDLE: begin
                if (req_start) begin
                    r_d.err = ERR_NONE;
                    if (req_len == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.wr    = req_write;
                        r_d.addr  = req_addr;
                        r_d.ptr   = '0;
                        r_d.rem   = req_len;
                        r_d.blen  = burst_of(req_len);
                        r_d.tries = '0;
                        r_d.st    = ST_CLEAR;
                    end
                end
            end
            ST_CLEAR: begin
                buf_clr    = 1'b1;
                r_d.rflag  = 1'b0;
                r_d.eflag  = 1'b0;
                r_d.status = '0;
                r_d.idx    = '0;
                r_d.st     = r_q.wr ? ST_LOAD : ST_ISSUE;
            end
            ST_LOAD: begin
                buf_wr  = 1'b1;
                r_d.idx = r_q.idx + IDX_W'(1);
                if (idx_last) r_d.st = ST_ISSUE;
            end
            ST_ISSUE: begin
                tmr_lim = TMR_W'(EN_LIM);
                if (eng_accept) begin
                    r_d.st = ST_WAIT;
                end else begin
                    tmr_clr = 1'b0;
                    if (tmr_hit) begin
                        fail      = 1'b1;
                        fail_code = ERR_EN_TMO;
                    end
                end
            end
            ST_WAIT: begin
                tmr_clr = 1'b0;
                if (eng_reply) begin
                    r_d.rflag  = 1'b1;
                    r_d.eflag  = eng_err;
                    r_d.status = eng_status;
                    buf_cap    = !r_q.wr;
                    r_d.st     = ST_CHECK;
                end else if (tmr_hit) begin
                    fail      = 1'b1;
                    fail_code = ERR_RPLY_TMO;
                end
            end
            ST_CHECK: begin
                r_d.idx = '0;
                if (!r_q.rflag) begin
                    fail      = 1'b1;
                    fail_code = ERR_RPLY_TMO;
                end else if (r_q.eflag) begin
                    fail      = 1'b1;
                    fail_code = ERR_ACCESS;
                end else if (r_q.status != 4'd0) begin
                    fail      = 1'b1;
                    fail_code = ERR_STATUS;
                end else begin
                    r_d.st = r_q.wr ? ST_ADVANCE : ST_UNLOAD;
                end
            end
            ST_UNLOAD: begin
                r_d.idx = r_q.idx + IDX_W'(1);
                if (idx_last) r_d.st = ST_ADVANCE;
            end
            ST_ADVANCE: begin
                r_d.addr  = r_q.addr + 20'(r_q.blen);
                r_d.ptr   = r_q.ptr + LEN_W'(r_q.blen);
                r_d.rem   = r_q.rem - LEN_W'(r_q.blen);
                r_d.tries = '0;
                if (r_q.rem == LEN_W'(r_q.blen)) begin
                    r_d.done = 1'b1;
                    r_d.err  = ERR_NONE;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.blen = burst_of(r_q.rem - LEN_W'(r_q.blen));
                    r_d.st   = ST_CLEAR;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (fail) begin
            r_d.err = fail_code;
            if (r_q.tries == TRY_W'(MAX_TRY - 1)) begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end else begin
                r_d.tries = r_q.tries + TRY_W'(1);
                r_d.st    = ST_CLEAR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    dpcd_burst_buf #(.BYTES(BURST), .IDX_W(IDX_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (buf_wr),
        .wr_idx   (r_q.idx),
        .wr_byte  (usr_wdata),
        .cap_en   (buf_cap),
        .cap_data (eng_rdata),
        .rd_idx   (r_q.idx),
        .rd_byte  (usr_rdata),
        .data     (eng_wdata)
    );

    dpcd_cycle_timer #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .lim   (tmr_lim),
        .hit   (tmr_hit)
    );

    assign busy         = (r_q.st != ST_IDLE);
    assign done         = r_q.done;
    assign err_code     = r_q.err;
    assign usr_idx      = r_q.ptr + LEN_W'(r_q.idx);
    assign usr_we       = (r_q.st == ST_UNLOAD);
    assign eng_go       = (r_q.st == ST_ISSUE);
    assign eng_addr_lo  = r_q.addr[7:0];
    assign eng_addr_mid = r_q.addr[15:8];
    assign eng_addr_hi  = r_q.addr[19:16];

    always_comb begin
        eng_cmd = 8'h00;
        eng_cmd[CMD_LEN_LSB +: 4]  = 4'(blen_m1);
        eng_cmd[CMD_NATIVE_BIT]    = 1'b1;
        eng_cmd[CMD_READ_BIT]      = !r_q.wr;
    end

    assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> (r_q.blen != '0 && r_q.blen <= BLEN_W'(BURST)
                    && LEN_W'(r_q.blen) <= r_q.rem));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_go && $past(eng_go)) |-> $stable({eng_addr_hi, eng_addr_mid, eng_addr_lo}));

    assert_try_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.tries < TRY_W'(MAX_TRY)));

    assert_accept_drops_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_go && eng_accept) |=> !eng_go);

    assert_unload_after_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        usr_we |-> (r_q.rflag && !r_q.eflag && r_q.status == 4'd0 && !r_q.wr));

    assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(r_q.wr));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/dpcd_burst_seq_tb.sv
module dpcd_burst_seq_tb;

    localparam int LEN_W = 16;
    localparam int BURST = 16;
    localparam int BW    = BURST * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_start = 1'b0, req_write = 1'b0;
    logic [19:0]       req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              busy, done, usr_we, eng_go;
    logic [2:0]        err_code;
    logic [LEN_W-1:0]  usr_idx;
    logic [7:0]        usr_wdata, usr_rdata, eng_cmd, eng_addr_lo, eng_addr_mid;
    logic [3:0]        eng_addr_hi;
    logic [BW-1:0]     eng_wdata;
    logic              eng_accept = 1'b0, eng_reply = 1'b0, eng_err = 1'b0;
    logic [3:0]        eng_status = '0;
    logic [BW-1:0]     eng_rdata = '0;

    always #2.5 clk = ~clk;

    dpcd_burst_seq #(.LEN_W(LEN_W), .BURST(BURST), .MAX_TRY(10), .CYC_PER_MS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
        .err_code(err_code), .usr_idx(usr_idx), .usr_wdata(usr_wdata),
        .usr_we(usr_we), .usr_rdata(usr_rdata), .eng_go(eng_go), .eng_cmd(eng_cmd),
        .eng_addr_lo(eng_addr_lo), .eng_addr_mid(eng_addr_mid), .eng_addr_hi(eng_addr_hi),
        .eng_wdata(eng_wdata), .eng_accept(eng_accept), .eng_reply(eng_reply),
        .eng_err(eng_err), .eng_status(eng_status), .eng_rdata(eng_rdata)
    );

    logic [7:0] src [256];
    logic [7:0] sink [int];
    int script [$];
    int n_chk = 0, n_err = 0;
    bit t_wr;
    int t_addr, t_len, t_off, n_rd_seen, n_go;
    bit prev_done = 1'b0;

    assign usr_wdata = src[usr_idx[7:0]];

    function automatic logic [7:0] byte_at(input int a);
        int m;
        m = a & 32'hFFFFF;
        if (sink.exists(m)) return sink[m];
        return m[7:0] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // engine responder and request checker (model of the expected bursts)
    initial begin
        forever begin
            int blen, k, ea;
            bit pay_ok, pad_ok;
            @(negedge clk);
            if (!(rst_n && eng_go)) continue;
            n_go++;
            blen = (t_len - t_off > BURST) ? BURST : t_len - t_off;
            ea = (t_addr + t_off) & 32'hFFFFF;
            chk({eng_addr_hi, eng_addr_mid, eng_addr_lo} == 20'(ea), "R4 address fields",
                {eng_addr_hi, eng_addr_mid, eng_addr_lo}, ea);
            chk(eng_cmd[7:4] == 4'(blen - 1), "R2 burst length field", eng_cmd[7:4], blen - 1);
            chk(eng_cmd[3:0] == {1'b1, 2'b00, !t_wr}, "R3 native bit and direction",
                eng_cmd[3:0], {1'b1, 2'b00, !t_wr});
            pay_ok = 1'b1;
            pad_ok = 1'b1;
            for (int i = 0; i < BURST; i++) begin
                if (t_wr && i < blen) begin
                    if (eng_wdata[i*8 +: 8] != src[t_off + i]) pay_ok = 1'b0;
                end else if (eng_wdata[i*8 +: 8] != 8'h00) pad_ok = 1'b0;
            end
            chk(pay_ok, "R8 payload loaded before request", 0, 0);
            chk(pad_ok, "R7 unused buffer bytes cleared", 0, 0);
            k = (script.size() > 0) ? script.pop_front() : 0;
            if (k == 1) begin
                while (eng_go) @(negedge clk);
                continue;
            end
            repeat (2) @(negedge clk);
            eng_accept = 1'b1;
            @(negedge clk);
            eng_accept = 1'b0;
            if (k == 2) continue;
            repeat (3) @(negedge clk);
            eng_reply  = 1'b1;
            eng_err    = (k == 3 || k == 5);
            eng_status = (k == 4 || k == 5) ? 4'h6 : 4'h0;
            for (int i = 0; i < BURST; i++)
                eng_rdata[i*8 +: 8] = (i < blen) ? byte_at(t_addr + t_off + i) : 8'hEE;
            @(negedge clk);
            eng_reply  = 1'b0;
            eng_err    = 1'b0;
            eng_status = 4'h0;
            if (k == 0) begin
                if (t_wr)
                    for (int i = 0; i < blen; i++)
                        sink[(t_addr + t_off + i) & 32'hFFFFF] = src[t_off + i];
                t_off += blen;
            end
        end
    end

    // per-clock monitor of the caller side
    always @(negedge clk) begin
        if (rst_n) begin
            if (usr_we) begin
                chk(!t_wr, "R9 no read strobe on write", 1, 0);
                chk(usr_idx == LEN_W'(n_rd_seen), "R9 ascending index", usr_idx, n_rd_seen);
                chk(int'(usr_idx) < t_off, "R9 only after success", usr_idx, t_off);
                chk(usr_rdata == byte_at(t_addr + int'(usr_idx)), "R9 read byte",
                    usr_rdata, byte_at(t_addr + int'(usr_idx)));
                n_rd_seen++;
            end
            if (prev_done) chk(!done && !busy, "R11 single cycle done", {done, busy}, 0);
            prev_done = done;
        end
    end

    task automatic run(input bit wr, input int addr, input int len, input int exp_err,
                       input bit poke);
        int cyc, go0;
        bit ok;
        @(negedge clk);
        t_wr = wr; t_addr = addr; t_len = len; t_off = 0; n_rd_seen = 0;
        go0 = n_go;
        req_write = wr; req_addr = 20'(addr); req_len = LEN_W'(len); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 6) begin
                req_write = !wr; req_addr = 20'h00003; req_len = LEN_W'(3); req_start = 1'b1;
            end else begin
                req_start = 1'b0;
            end
        end
        req_start = 1'b0;
        chk(done, "R11 done reached", done, 1);
        chk(err_code == 3'(exp_err), "R5 R6 error code", err_code, exp_err);
        if (len == 0) begin
            chk(cyc == 0, "R1 immediate done", cyc, 0);
            chk(n_go == go0, "R1 no engine request", n_go - go0, 0);
        end
        if (exp_err == 0) begin
            chk(t_off == len, "R4 bytes moved", t_off, len);
            if (!wr) chk(n_rd_seen == len, "R9 read byte count", n_rd_seen, len);
            if (wr) begin
                ok = 1'b1;
                for (int i = 0; i < len; i++)
                    if (byte_at(addr + i) != src[i]) ok = 1'b0;
                chk(ok, "R8 write data at target", 0, 0);
            end
        end else begin
            chk(n_rd_seen == t_off, "R9 nothing delivered on abort", n_rd_seen, t_off);
        end
        @(negedge clk);
        chk(!busy && !done, "R11 idle after done", {busy, done}, 0);
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) src[i] = 8'(i * 7 + 3);
        n_go = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !eng_go && !usr_we, "R11 reset state",
            {busy, done, eng_go, usr_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(1'b0, 20'h00100, 0, 0, 1'b0);              // R1
        run(1'b1, 20'h12345, 5, 0, 1'b0);              // R8 single burst write
        run(1'b0, 20'h12345, 5, 0, 1'b0);              // R9 read back
        run(1'b1, 20'h0FFF8, 40, 0, 1'b0);             // R2 R4 carry into upper field
        run(1'b0, 20'h0FFF8, 40, 0, 1'b0);
        run(1'b1, 20'h00200, 16, 0, 1'b0);             // R2 exact burst
        script = {1, 2, 3, 4, 5, 0};                   // R5 R6 retries then pass
        run(1'b0, 20'h0FFF8, 20, 0, 1'b0);
        for (int i = 0; i < 9; i++) script.push_back(4);
        script.push_back(5);                           // R6 error flag outranks status
        run(1'b0, 20'h00300, 7, 3, 1'b0);
        for (int i = 0; i < 10; i++) script.push_back(4);
        run(1'b1, 20'h00400, 3, 4, 1'b0);
        for (int i = 0; i < 10; i++) script.push_back(1);
        run(1'b0, 20'h00500, 4, 1, 1'b0);              // R6 enable timeout
        for (int i = 0; i < 10; i++) script.push_back(2);
        run(1'b1, 20'h00600, 4, 2, 1'b0);              // R6 reply timeout
        run(1'b1, 20'h00700, 24, 0, 1'b1);             // R10 start while busy
        run(1'b0, 20'h00700, 24, 0, 1'b0);

        summary();
        $finish;
    end

endmodule